// File: doc/BRIEF.md
# Latched serial command receiver

This block takes 24-bit command frames from a three-wire serial link and steers each frame into one of two parallel registers: a configuration register for a boost and output controller, or an output-channel mask. The host pulls the active-low latch strobe low, which selects the receiver and empties its shift register. It then clocks in the frame most significant bit first, and finally raises the strobe, which commits the frame. Bit 0 of the frame chooses the destination.

The serial clock, serial data and latch strobe are all oversampled by a faster system clock through two-flop synchronisers. Edges are found in the system-clock domain, so the serial clock must run well below the system clock. While the strobe is high the receiver ignores the serial clock, so other devices can share the wires.

Top module: `serial_cmd_rx`

## Requirements
- R1: The shift register is 24 bits wide. Each accepted serial-clock falling edge shifts it one place toward the MSB and takes the data bit in at bit 0, so frames arrive MSB first and bits older than the last 24 are lost.
- R2: Serial-clock edges change the shift register only while the latch strobe is low; with the strobe high they alter neither it nor either output register.
- R3: A falling edge of the latch strobe clears the shift register to zero before any new bit is taken.
- R4: A rising edge of the latch strobe commits the shift register. Frame bit 0 = 0 writes the configuration register only; bit 0 = 1 writes the channel mask only; the other register keeps its value.
- R5: Configuration fields are taken from frame bits: bit 8 to cur_lim_off_o, bit 7 to sync_release_o, bit 6 to soft_start_off_o, bits 5:4 to cur_lim_sel_o, bits 3:1 to volt_sel_o; bits 23:9 have no effect.
- R6: Channel mask bit n (n = 0..20) is taken from frame bit n+1; frame bits 23:22 have no effect.
- R7: Synchronous active-high reset clears both output registers and the shift register to zero.
- R8: A frame with fewer or more than 24 serial-clock pulses is still committed, using whatever the shift register holds at the strobe's rising edge.
- R9: Output registers take their new value at the third system-clock rising edge after the strobe rises (two synchroniser stages plus the output register), and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high power-on reset |
| sclk_i | input | 1 | Serial clock, data taken on its falling edge |
| sdata_i | input | 1 | Serial data, MSB first |
| latch_n_i | input | 1 | Active-low select; falling edge clears, rising edge commits |
| cur_lim_off_o | output | 1 | Current-limit disable |
| sync_release_o | output | 1 | Synchronised regulator release enable |
| soft_start_off_o | output | 1 | Soft-start disable |
| cur_lim_sel_o | output | 2 | Current-limit select |
| volt_sel_o | output | 3 | Boost voltage select (0 means shutdown) |
| chan_mask_o | output | 21 | Per-channel drive mask |

## Verification
The assertions assume that the serial clock and latch strobe hold each level for several system clocks, so that every edge is seen once after synchronisation. They also assume that serial data is steady around each serial-clock falling edge, and that the strobe never moves on the same system clock as a serial-clock fall. The stimulus holds every serial-clock phase for four system clocks, changes data only while the serial clock is low, and leaves four system clocks between the last serial-clock fall and any strobe edge.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int FRAME_W_DEF = 24;
  localparam int CHAN_N_DEF  = 21;
  localparam int SYNC_N_DEF  = 2;

  // frame bit that picks the destination register
  localparam int SEL_BIT = 0;
  // configuration field positions inside the frame
  localparam int VSEL_LSB = 1;
  localparam int LSEL_LSB = 4;
  localparam int SSOFF_BIT = 6;
  localparam int SYNC_BIT  = 7;
  localparam int LOFF_BIT  = 8;
  localparam int CFG_TOP   = LOFF_BIT;

  typedef struct packed {
    logic       lim_off;
    logic       sync_rel;
    logic       ss_off;
    logic [1:0] lim_sel;
    logic [2:0] volt_sel;
  } cfg_t;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[k] <= RST_VAL;
          else     stg[k] <= stg[k-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_prev <= RST_VAL;
    else     q_prev <= stg[STAGES-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scr_shifter.sv
module scr_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr)    q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/scr_regbank.sv
module scr_regbank
  import scr_pkg::*;
#(
  parameter int CHAN_N = 21,
  localparam int FW = CHAN_N + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [FW-1:0]     frame,
  output cfg_t              cfg_q,
  output logic [CHAN_N-1:0] mask_q
);
  logic cfg_we, mask_we;
  cfg_t cfg_d;
  logic [CHAN_N-1:0] mask_d;

  assign cfg_we  = commit & ~frame[SEL_BIT];
  assign mask_we = commit &  frame[SEL_BIT];

  assign cfg_d.lim_off  = frame[LOFF_BIT];
  assign cfg_d.sync_rel = frame[SYNC_BIT];
  assign cfg_d.ss_off   = frame[SSOFF_BIT];
  assign cfg_d.lim_sel  = frame[LSEL_LSB +: 2];
  assign cfg_d.volt_sel = frame[VSEL_LSB +: 3];

  generate
    for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
      assign mask_d[c] = frame[c + 1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import scr_pkg::*;
#(
  parameter int FRAME_W = FRAME_W_DEF,
  parameter int CHAN_N  = CHAN_N_DEF,
  parameter int SYNC_N  = SYNC_N_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              latch_n_i,
  output logic              cur_lim_off_o,
  output logic              sync_release_o,
  output logic              soft_start_off_o,
  output logic [1:0]        cur_lim_sel_o,
  output logic [2:0]        volt_sel_o,
  output logic [CHAN_N-1:0] chan_mask_o
);
  localparam int IDX_SCLK = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_LAT  = 2;
  localparam logic [2:0] SYNC_RST = 3'b100; // strobe idles high

  logic [2:0] in_q, in_prev;
  logic sclk_fall, le_low, le_rise, le_fall, sdin;
  logic [FRAME_W-1:0] shreg;
  cfg_t cfg_q;

  scr_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({latch_n_i, sdata_i, sclk_i}),
    .q(in_q), .q_prev(in_prev)
  );

  assign sdin      = in_q[IDX_DATA];
  assign le_low    = ~in_q[IDX_LAT];
  assign le_fall   = ~in_q[IDX_LAT] &  in_prev[IDX_LAT];
  assign le_rise   =  in_q[IDX_LAT] & ~in_prev[IDX_LAT];
  assign sclk_fall = ~in_q[IDX_SCLK] & in_prev[IDX_SCLK];

  scr_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .clr(le_fall),
    .shift_en(sclk_fall & le_low),
    .din(sdin),
    .q(shreg)
  );

  scr_regbank #(.CHAN_N(CHAN_N)) u_regs (
    .clk(clk), .rst(rst),
    .commit(le_rise),
    .frame(shreg[CHAN_N:0]),
    .cfg_q(cfg_q),
    .mask_q(chan_mask_o)
  );

  assign cur_lim_off_o    = cfg_q.lim_off;
  assign sync_release_o   = cfg_q.sync_rel;
  assign soft_start_off_o = cfg_q.ss_off;
  assign cur_lim_sel_o    = cfg_q.lim_sel;
  assign volt_sel_o       = cfg_q.volt_sel;
endmodule

// File: rtl/serial_cmd_rx_chk.sv
module serial_cmd_rx_chk #(
  parameter int FRAME_W = 24,
  parameter int CHAN_N  = 21
) (
  input logic               clk,
  input logic               rst,
  input logic               sclk_fall,
  input logic               le_low,
  input logic               le_rise,
  input logic               le_fall,
  input logic               sdin,
  input logic [FRAME_W-1:0] shreg,
  input logic [7:0]         cfg_vec,
  input logic [CHAN_N-1:0]  chan_mask
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R7: one cycle after reset everything reads zero
  always_ff @(posedge clk) begin
    if (rst_q) begin
      p_reset_clear_r7: assert (shreg == '0 && cfg_vec == '0 && chan_mask == '0)
        else $error("R7 reset did not clear state");
    end
  end

  p_shift_in_r1: assert property (@(posedge clk) disable iff (rst)
    (sclk_fall && le_low && !le_fall) |=> shreg == {$past(shreg[FRAME_W-2:0]), $past(sdin)});

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !le_low |=> $stable(shreg));

  p_fall_clear_r3: assert property (@(posedge clk) disable iff (rst)
    le_fall |=> shreg == '0);

  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(le_rise && !shreg[0]) |=> $stable(cfg_vec));

  p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(le_rise && shreg[0]) |=> $stable(chan_mask));

  p_cfg_load_r5: assert property (@(posedge clk) disable iff (rst)
    (le_rise && !shreg[0]) |=> cfg_vec == $past(shreg[8:1]));

  p_mask_load_r6: assert property (@(posedge clk) disable iff (rst)
    (le_rise && shreg[0]) |=> chan_mask == $past(shreg[CHAN_N:1]));
endmodule

bind serial_cmd_rx serial_cmd_rx_chk #(.FRAME_W(FRAME_W), .CHAN_N(CHAN_N)) u_chk (
  .clk(clk), .rst(rst),
  .sclk_fall(sclk_fall), .le_low(le_low), .le_rise(le_rise), .le_fall(le_fall),
  .sdin(sdin), .shreg(shreg), .cfg_vec(cfg_q), .chan_mask(chan_mask_o)
);

// File: tb/serial_cmd_rx_test.sv
module serial_cmd_rx_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, latch_n = 1'b1;
  logic cur_lim_off, sync_release, soft_start_off;
  logic [1:0] cur_lim_sel;
  logic [2:0] volt_sel;
  logic [20:0] chan_mask;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_cmd_rx uut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata), .latch_n_i(latch_n),
    .cur_lim_off_o(cur_lim_off), .sync_release_o(sync_release),
    .soft_start_off_o(soft_start_off), .cur_lim_sel_o(cur_lim_sel),
    .volt_sel_o(volt_sel), .chan_mask_o(chan_mask)
  );

  function automatic logic [31:0] cfg_now();
    return {24'd0, cur_lim_off, sync_release, soft_start_off, cur_lim_sel, volt_sel};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe low, then n bits of v MSB first; strobe left low
  task automatic open_and_shift(logic [31:0] v, int n);
    latch_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i];
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
    end
  endtask

  task automatic send(logic [31:0] v, int n);
    open_and_shift(v, n);
    latch_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic t_reset();
    chk("R7 reset cfg", cfg_now(), 32'd0);
    chk("R7 reset mask", {11'd0, chan_mask}, 32'd0);
  endtask

  task automatic t_config();
    logic [23:0] f = 24'h00015A;
    send({8'd0, f}, 24);
    chk("R5 config fields", cfg_now(), {24'd0, f[8:1]});
    chk("R4 mask untouched by config", {11'd0, chan_mask}, 32'd0);
  endtask

  task automatic t_mask();
    logic [23:0] f = 24'hC5A397;
    logic [31:0] c0 = cfg_now();
    send({8'd0, f}, 24);
    chk("R6 mask bits, 23:22 ignored", {11'd0, chan_mask}, {11'd0, f[21:1]});
    chk("R4 config untouched by mask", cfg_now(), c0);
  endtask

  task automatic t_cfg_ignored();
    logic [23:0] f = 24'hFFFE16;
    logic [20:0] m0 = chan_mask;
    send({8'd0, f}, 24);
    chk("R5 upper config bits ignored", cfg_now(), {24'd0, f[8:1]});
    chk("R4 mask kept", {11'd0, chan_mask}, {11'd0, m0});
  endtask

  task automatic t_idle_clock();
    logic [31:0] c0 = cfg_now();
    logic [20:0] m0 = chan_mask;
    sdata = 1'b1;
    for (int i = 0; i < 30; i++) begin
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    wait_clk(6);
    chk("R2 idle clocks keep config", cfg_now(), c0);
    chk("R2 idle clocks keep mask", {11'd0, chan_mask}, {11'd0, m0});
  endtask

  task automatic t_short();
    send(32'h3, 2);
    chk("R3 R8 short frame after clear", {11'd0, chan_mask}, 32'd1);
  endtask

  task automatic t_long();
    logic [31:0] v = 32'h03123457;
    send(v, 26);
    chk("R1 R8 long frame keeps last 24", {11'd0, chan_mask}, {11'd0, v[21:1]});
  endtask

  task automatic t_latency();
    logic [23:0] f = 24'h0000AB;
    logic [20:0] m0 = chan_mask;
    open_and_shift({8'd0, f}, 24);
    latch_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 no update after two edges", {11'd0, chan_mask}, {11'd0, m0});
    @(posedge clk); #1;
    chk("R9 update at third edge", {11'd0, chan_mask}, {11'd0, f[21:1]});
    wait_clk(4);
  endtask

  task automatic t_por();
    @(negedge clk); rst = 1'b1;
    wait_clk(2); rst = 1'b0;
    wait_clk(2);
    chk("R7 reset clears config", cfg_now(), 32'd0);
    chk("R7 reset clears mask", {11'd0, chan_mask}, 32'd0);
    send(32'h1, 1);
    chk("R7 R3 empty frame after reset", {11'd0, chan_mask}, 32'd0);
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(3);
    t_reset();
    t_config();
    t_mask();
    t_cfg_ignored();
    t_idle_clock();
    t_short();
    t_long();
    t_latency();
    t_por();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule